// File: doc/BRIEF.md
# ARINC 429 Receive Bit Qualifier

This block turns the two digital comparator outputs of an ARINC 429 receive line into 32-bit words. One comparator reports a positive ("one") level and the other a negative ("zero") level. When neither is asserted, the line is null. The line is oversampled at ten samples per data bit. A data bit is taken only when a clean run of one or zero samples is followed by a clean run of null samples. Successive bits must arrive with a spacing that lies inside a fixed window.

After the 32nd good bit, the block strobes `eos` for one clock and presents the word. In that word, the last bit position is replaced by a parity-check flag. A malformed bit, a spacing violation, a reset or a completed word all send the receiver back to waiting for a word gap. The gap is a run of null checks, taken at a fixed interval, that must be seen before the next word may begin.

The sample rate follows a master clock enable. The enable is used directly in fast mode, or divided by eight in slow mode.

Top module: `a429_bit_qualifier`

## Requirements
- R1: A sample is taken on every cycle with `clk_en` high when `slow_mode` is 0, and on every eighth `clk_en` cycle when `slow_mode` is 1. The eight-count runs freely from reset.
- R2: Each sample is classed as follows: ONE when only `line_one` is high, ZERO when only `line_zero` is high, NULL when both are low, and invalid when both are high. An invalid sample never counts as a ONE, ZERO or NULL.
- R3: A data bit is recognised at the sample that completes three NULL samples, provided the three samples just before them are all ONE (bit value 1) or all ZERO (bit value 0).
- R4: Once a word has started, each further bit must be recognised 8 to 12 samples after the previous one. A bit that is early, or 12 samples that pass with no bit, abandons the word and returns the receiver to waiting for a gap.
- R5: When the 32nd bit of a word is recognised, `eos` is high for exactly one clock cycle, on the cycle after that sampling edge.
- R6: At `eos`, `word_out[k-1]` holds received bit k for k = 1..31, where bit 1 is the first received. `word_out[31]` is 0 when the 32 received bits hold an odd number of ones and 1 when they hold an even number. `word_out` changes only when `eos` is high.
- R7: In the gap-wait state, a check is made every 10 samples. Each check passes if the last 6 samples, up to and including the current one, are NULL. A failing check restarts the count. After three passing checks in a row, the next word may start. Bits that arrive while waiting are ignored.
- R8: A synchronous active-high `rst` clears `eos` and `word_out` to 0, clears the sample history, and places the receiver in the gap-wait state with its counts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Master sampling clock enable |
| slow_mode | input | 1 | 1 selects one sample per eight enables |
| line_one | input | 1 | Positive-level comparator output |
| line_zero | input | 1 | Negative-level comparator output |
| eos | output | 1 | One-cycle strobe when a word is complete |
| word_out | output | 32 | Received word with the parity flag in bit 31 |

## Verification
The hardest behaviour to reach from the ports is the rejection at the exact edges of the spacing window. Spacings of 8 and 12 samples must be accepted, while 7 and 13 must be rejected. A word must then be silently ignored until a full gap has been seen. The stimulus builds each bit from a chosen number of level samples and null samples, which places every bit spacing exactly. Other stimuli insert a single invalid sample, a two-sample glitch, a gap that is too short, or a reset in mid-word. A behavioural model with a sample queue is compared against the outputs on every clock.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    ST_GAP  = 2'd0,
    ST_IDLE = 2'd1,
    ST_RX   = 2'd2
  } rx_state_t;
endpackage

// File: rtl/a429_sample_tick.sv
module a429_sample_tick #(
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic slow_mode,
  output logic tick
);
  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (clk_en) begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign tick = clk_en & (~slow_mode | (div_q == DIV_LAST));
endmodule

// File: rtl/a429_line_sampler.sv
module a429_line_sampler #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_one,
  input  logic line_zero,
  output logic bit_seen,
  output logic bit_val,
  output logic gap_null
);
  localparam int WIN = 2 * RUN;

  // class index: 0 = one, 1 = zero, 2 = null
  logic [2:0]     cls;
  logic [WIN-1:0] hist_q [3];
  logic [WIN-1:0] hist_n [3];

  assign cls[0] = line_one & ~line_zero;
  assign cls[1] = line_zero & ~line_one;
  assign cls[2] = ~line_one & ~line_zero;

  for (genvar g = 0; g < 3; g++) begin : g_hist
    assign hist_n[g] = {hist_q[g][WIN-2:0], cls[g]};
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[g] <= '0;
      end else if (tick) begin
        hist_q[g] <= hist_n[g];
      end
    end
  end

  logic tail_null, head_one, head_zero;
  assign tail_null = &hist_n[2][RUN-1:0];
  assign head_one  = &hist_n[0][WIN-1:RUN];
  assign head_zero = &hist_n[1][WIN-1:RUN];

  assign bit_seen = tick & tail_null & (head_one | head_zero);
  assign bit_val  = head_one;
  assign gap_null = tick & (&hist_n[2]);
endmodule

// File: rtl/a429_word_seq.sv
module a429_word_seq
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS  = 32,
  parameter int MIN_SP     = 8,
  parameter int MAX_SP     = 12,
  parameter int GAP_PERIOD = 10,
  parameter int GAP_CHECKS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 bit_seen,
  input  logic                 bit_val,
  input  logic                 gap_null,
  output logic                 eos,
  output logic [WORD_BITS-1:0] word_out,
  output rx_state_t            state
);
  localparam int SPW = $clog2(MAX_SP + 1);
  localparam int NBW = $clog2(WORD_BITS);
  localparam int PW  = $clog2(GAP_PERIOD);
  localparam int GW  = (GAP_CHECKS > 1) ? $clog2(GAP_CHECKS) : 1;
  localparam logic [SPW-1:0] SP_MIN  = SPW'(MIN_SP);
  localparam logic [SPW-1:0] SP_MAX  = SPW'(MAX_SP);
  localparam logic [NBW-1:0] N_LAST  = NBW'(WORD_BITS - 1);
  localparam logic [PW-1:0]  P_LAST  = PW'(GAP_PERIOD - 1);
  localparam logic [GW-1:0]  G_LAST  = GW'(GAP_CHECKS - 1);

  logic [WORD_BITS-2:0] shreg;
  logic [WORD_BITS-1:0] full;
  logic [SPW-1:0]       space_q, space_n;
  logic [NBW-1:0]       nbits;
  logic [PW-1:0]        per;
  logic [GW-1:0]        gcnt;
  logic                 spacing_ok;

  assign full       = {bit_val, shreg};
  assign space_n    = space_q + 1'b1;
  assign spacing_ok = (space_n >= SP_MIN) && (space_n <= SP_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_GAP;
      per      <= '0;
      gcnt     <= '0;
      nbits    <= '0;
      space_q  <= '0;
      shreg    <= '0;
      eos      <= 1'b0;
      word_out <= '0;
    end else begin
      eos <= 1'b0;
      if (tick) begin
        case (state)
          ST_GAP: begin
            if (per == P_LAST) begin
              per <= '0;
              if (gap_null) begin
                if (gcnt == G_LAST) begin
                  gcnt  <= '0;
                  state <= ST_IDLE;
                end else begin
                  gcnt <= gcnt + 1'b1;
                end
              end else begin
                gcnt <= '0;
              end
            end else begin
              per <= per + 1'b1;
            end
          end
          ST_IDLE: begin
            if (bit_seen) begin
              shreg   <= {bit_val, shreg[WORD_BITS-2:1]};
              nbits   <= NBW'(1);
              space_q <= '0;
              state   <= ST_RX;
            end
          end
          ST_RX: begin
            if (bit_seen && spacing_ok) begin
              shreg   <= {bit_val, shreg[WORD_BITS-2:1]};
              space_q <= '0;
              if (nbits == N_LAST) begin
                eos      <= 1'b1;
                word_out <= {~^full, full[WORD_BITS-2:0]};
                state    <= ST_GAP;
                per      <= '0;
                gcnt     <= '0;
              end else begin
                nbits <= nbits + 1'b1;
              end
            end else if (bit_seen || space_n >= SP_MAX) begin
              state <= ST_GAP;
              per   <= '0;
              gcnt  <= '0;
            end else begin
              space_q <= space_n;
            end
          end
          default: state <= ST_GAP;
        endcase
      end
    end
  end
endmodule

// File: rtl/a429_bit_qualifier.sv
module a429_bit_qualifier
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS  = 32,
  parameter int SLOW_DIV   = 8,
  parameter int RUN        = 3,
  parameter int MIN_SP     = 8,
  parameter int MAX_SP     = 12,
  parameter int GAP_PERIOD = 10,
  parameter int GAP_CHECKS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  logic                 slow_mode,
  input  logic                 line_one,
  input  logic                 line_zero,
  output logic                 eos,
  output logic [WORD_BITS-1:0] word_out
);
  logic      tick;
  logic      bit_seen, bit_val, gap_null;
  rx_state_t state;

  a429_sample_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .clk_en(clk_en), .slow_mode(slow_mode), .tick(tick)
  );

  a429_line_sampler #(.RUN(RUN)) u_samp (
    .clk(clk), .rst(rst), .tick(tick), .line_one(line_one), .line_zero(line_zero),
    .bit_seen(bit_seen), .bit_val(bit_val), .gap_null(gap_null)
  );

  a429_word_seq #(
    .WORD_BITS(WORD_BITS), .MIN_SP(MIN_SP), .MAX_SP(MAX_SP),
    .GAP_PERIOD(GAP_PERIOD), .GAP_CHECKS(GAP_CHECKS)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .bit_seen(bit_seen), .bit_val(bit_val),
    .gap_null(gap_null), .eos(eos), .word_out(word_out), .state(state)
  );
endmodule

// File: rtl/a429_bit_qualifier_chk.sv
module a429_bit_qualifier_chk
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 slow_mode,
  input logic                 tick,
  input logic                 bit_seen,
  input logic                 eos,
  input logic [WORD_BITS-1:0] word_out,
  input rx_state_t            state
);
  AST_EOS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eos |=> !eos); // R5

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_out) |-> eos); // R6

  AST_EOS_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
    eos |-> ($past(bit_seen) && $past(tick))); // R3

  AST_SLOW_TICK_SPARSE: assert property (@(posedge clk) disable iff (rst)
    (slow_mode && $past(slow_mode) && tick) |-> !$past(tick)); // R1

  AST_GAP_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
    eos |-> (state == ST_GAP)); // R7
endmodule

bind a429_bit_qualifier a429_bit_qualifier_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst(rst), .slow_mode(slow_mode), .tick(tick), .bit_seen(bit_seen),
  .eos(eos), .word_out(word_out), .state(state)
);

// File: tb/a429_bit_qualifier_tb.sv
module a429_bit_qualifier_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b1;
  logic        slow_mode = 1'b0;
  logic        line_one = 1'b0;
  logic        line_zero = 1'b0;
  logic        eos;
  logic [31:0] word_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int n_eos = 0;
  logic [31:0] last_word = '0;

  always #(CLK_P/2) clk = ~clk;

  a429_bit_qualifier u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .slow_mode(slow_mode),
    .line_one(line_one), .line_zero(line_zero), .eos(eos), .word_out(word_out)
  );

  // ---------------- behavioural reference model ----------------
  // sample codes: 0 one, 1 zero, 2 null, 3 invalid
  int hist[$];
  int m_state = 0;   // 0 wait gap, 1 armed, 2 receiving
  int m_div = 0, m_per = 0, m_gcnt = 0, m_nb = 0, m_sp = 0;
  logic [30:0] m_acc = '0;
  logic        m_eos = 1'b0;
  logic [31:0] m_word = '0;

  function automatic bit run_is(int from, int code);
    if (hist.size() < from + 3) return 1'b0;
    for (int k = from; k < from + 3; k++) if (hist[k] != code) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      m_state = 0; m_div = 0; m_per = 0; m_gcnt = 0; m_nb = 0; m_sp = 0;
      m_acc = '0; m_eos = 1'b0; m_word = '0;
    end else begin
      bit tk, bs, bv, gn;
      int c;
      m_eos = 1'b0;
      tk = clk_en && (!slow_mode || m_div == 7);
      if (clk_en) m_div = (m_div + 1) % 8;
      if (tk) begin
        c = (line_one && line_zero) ? 3 : line_one ? 0 : line_zero ? 1 : 2;
        hist.push_front(c);
        if (hist.size() > 6) void'(hist.pop_back());
        bs = run_is(0, 2) && (run_is(3, 0) || run_is(3, 1));
        bv = run_is(3, 0);
        gn = run_is(0, 2) && run_is(3, 2);
        if (m_state == 0) begin
          if (m_per == 9) begin
            m_per = 0;
            if (gn) begin
              if (m_gcnt == 2) begin m_gcnt = 0; m_state = 1; end
              else m_gcnt++;
            end else m_gcnt = 0;
          end else m_per++;
        end else if (m_state == 1) begin
          if (bs) begin m_acc = {bv, m_acc[30:1]}; m_nb = 1; m_sp = 0; m_state = 2; end
        end else begin
          int n;
          n = m_sp + 1;
          if (bs && n >= 8 && n <= 12) begin
            if (m_nb == 31) begin
              logic [31:0] f;
              f = {bv, m_acc};
              m_word = {~^f, f[30:0]};
              m_eos = 1'b1;
              m_state = 0; m_per = 0; m_gcnt = 0;
            end else m_nb++;
            m_acc = {bv, m_acc[30:1]};
            m_sp = 0;
          end else if (bs || n >= 12) begin
            m_state = 0; m_per = 0; m_gcnt = 0;
          end else m_sp = n;
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (eos !== m_eos) begin
        errors++;
        $display("FAIL R5 eos at %0t: actual=%0b expected=%0b", $time, eos, m_eos);
      end
      checks++;
      if (word_out !== m_word) begin
        errors++;
        $display("FAIL R6 word_out at %0t: actual=%08h expected=%08h", $time, word_out, m_word);
      end
      if (eos === 1'b1) begin n_eos++; last_word = word_out; end
    end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic put(int code, int n);
    line_one  = (code == 0 || code == 3);
    line_zero = (code == 1 || code == 3);
    repeat (n * (slow_mode ? 8 : 1)) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_word(logic [31:0] w);
    return {~^w, w[30:0]};
  endfunction

  task automatic send_word(logic [31:0] w, int hi, int lo, int gap, int bad_at, int glitch_at);
    for (int i = 0; i < 32; i++) begin
      int lv;
      lv = w[i] ? 0 : 1;
      if (i == glitch_at) begin
        put(lv, 2); put(2, hi + lo - 2);
      end else if (i == bad_at) begin
        put(lv, hi - 1); put(3, 1); put(2, lo);
      end else begin
        put(lv, hi); put(2, lo);
      end
    end
    put(2, gap);
  endtask

  // ---------------- stimulus ----------------
  int exp_cnt = 0;
  initial begin
    repeat (4) @(negedge clk);
    check_eq("R8 eos in reset", {31'd0, eos}, 32'd0);
    check_eq("R8 word_out in reset", word_out, 32'd0);
    rst = 1'b0;
    put(2, 40);
    check_eq("R7 no word from idle line", n_eos, exp_cnt);

    send_word(32'h8123_4567, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R5 eos count basic", n_eos, exp_cnt);
    check_eq("R6 word basic", last_word, expect_word(32'h8123_4567));

    send_word(32'h0F0F_0F0F, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R6 even-parity flag", last_word, expect_word(32'h0F0F_0F0F));
    check_eq("R6 flag bit is one", {31'd0, last_word[31]}, 32'd1);

    send_word(32'h0000_0000, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R2 all-zero-level word", last_word, 32'h8000_0000);

    // short gap: second word must be ignored
    send_word(32'hA5A5_0001, 5, 5, 15, -1, -1); exp_cnt++;
    send_word(32'h1234_0002, 5, 5, 40, -1, -1);
    check_eq("R7 short gap count", n_eos, exp_cnt);
    check_eq("R7 short gap word", last_word, expect_word(32'hA5A5_0001));
    send_word(32'h5555_AAAA, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R7 rearmed after gap", last_word, expect_word(32'h5555_AAAA));

    // spacing window edges
    send_word(32'h3C3C_1111, 5, 7, 40, -1, -1); exp_cnt++;
    check_eq("R4 spacing 12 accepted", last_word, expect_word(32'h3C3C_1111));
    send_word(32'hC3C3_2222, 4, 4, 40, -1, -1); exp_cnt++;
    check_eq("R4 spacing 8 accepted", last_word, expect_word(32'hC3C3_2222));
    send_word(32'h7777_3333, 5, 8, 40, -1, -1);
    check_eq("R4 spacing 13 rejected", n_eos, exp_cnt);
    send_word(32'h6666_4444, 4, 3, 40, -1, -1);
    check_eq("R4 spacing 7 rejected", n_eos, exp_cnt);

    // malformed bits
    send_word(32'hFFFF_FFFF, 5, 5, 40, 9, -1);
    check_eq("R2 invalid sample rejects word", n_eos, exp_cnt);
    send_word(32'hFFFF_0000, 5, 5, 40, -1, 4);
    check_eq("R3 short pulse rejects word", n_eos, exp_cnt);
    check_eq("R3 word kept after rejects", last_word, expect_word(32'hC3C3_2222));

    // reset in mid-word
    for (int i = 0; i < 10; i++) begin put(0, 5); put(2, 5); end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R8 word_out cleared", word_out, 32'd0);
    rst = 1'b0;
    send_word(32'h1357_9BDF, 5, 5, 40, -1, -1);
    check_eq("R8 no word right after reset", n_eos, exp_cnt);
    send_word(32'h2468_ACE0, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R8 word after reset and gap", last_word, expect_word(32'h2468_ACE0));

    // slow sampling
    slow_mode = 1'b1;
    put(2, 40);
    send_word(32'h0BAD_F00D, 5, 5, 40, -1, -1); exp_cnt++;
    check_eq("R1 slow mode word", last_word, expect_word(32'h0BAD_F00D));
    check_eq("R1 slow mode count", n_eos, exp_cnt);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule